// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the interrupt and error state of a flash memory controller. A command engine reports the end of each operation through completion strobes (core reset done, erase done, program done, load done, or a plain completion with no class bit) and through four error strobes. These set bits in a 16-bit interrupt status word and in a controller status word. The host reads and writes both words, a configuration word and a command word through a small register port.

The host acknowledges an interrupt by writing a mask that is ANDed into the interrupt status. Once the master bit is clear, all error bits drop with it. While the master bit is set, a new command write is refused, so the engine never sees a command the host issued without first acknowledging the previous one. An accepted command leaves the block as a one-cycle start pulse with its code.

The interrupt pin is the master bit XORed with the inverse of a polarity bit in the configuration word. The ready pin is a configuration bit. Both pins are registered.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, the interrupt status reads 0x8080, the configuration reads 0x40C0, the controller status reads 0x0000, the command reads 0x0000, and both `int_o` and `rdy_o` are 1.
- R2: A cycle with `soft_rst_i` high sets the interrupt status to 0x8010, the configuration to 0x40C0, and the error bits and the command to zero. It overrides any event, error strobe or register write in the same cycle.
- R3: Each completion strobe ORs bit 15 plus its own class bit into the interrupt status on the clock edge where it is high: core reset done is bit 4, erase done is bit 5, program done is bit 6, load done is bit 7, and a plain completion sets bit 15 only. The new value is readable after that edge.
- R4: The error strobe `evt_err_i[0..3]` sets controller status bit 10 (command), 11 (erase), 12 (program) or 13 (load). Any error strobe also sets interrupt bit 15. No other controller status bit is ever 1.
- R5: A register write to address 0 replaces the interrupt status with the old status ANDed with the written data.
- R6: Whenever interrupt bit 15 is 0 after an edge, all four error bits are 0.
- R7: When a write to address 0 and a completion or error strobe fall in the same cycle, the result is (old AND data) OR event bits. Error bits survive if bit 15 ends up set.
- R8: A write to address 3 is accepted only if interrupt bit 15 was 0 before that edge. It then stores the code, readable at address 3, and raises `cmd_go_o` for exactly one cycle with `cmd_code_o` equal to the code. Otherwise the write has no effect on `cmd_go_o` or on the stored code.
- R9: `int_o` equals, one cycle late, interrupt bit 15 XOR the inverse of configuration bit 6.
- R10: `rdy_o` equals, one cycle late, configuration bit 7.
- R11: A write to address 2 stores all 16 bits. A read of address 2 returns the value with bits 4..0 forced to 0. Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold), released synchronously |
| soft_rst_i | input | 1 | Synchronous warm or hot reset strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 interrupt, 1 controller status, 2 configuration, 3 command |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register (combinational) |
| evt_rst_done_i | input | 1 | Core reset completion strobe |
| evt_erase_done_i | input | 1 | Erase completion strobe |
| evt_prog_done_i | input | 1 | Program completion strobe |
| evt_load_done_i | input | 1 | Load completion strobe |
| evt_generic_i | input | 1 | Completion strobe with no class bit |
| evt_err_i | input | 4 | Error strobes: command, erase, program, load |
| cmd_go_o | output | 1 | One-cycle pulse for an accepted command |
| cmd_code_o | output | 16 | Stored command code |
| int_o | output | 1 | Interrupt pin, polarity set by software |
| rdy_o | output | 1 | Ready pin |

## Verification
A host acknowledge (AND write to the interrupt word) can land in the same cycle as a completion or error strobe. A command write can also land in the cycle where a strobe raises the master bit. Directed steps place a mask of 0x7FFF together with an erase strobe while errors are pending. The result must be the masked value ORed with the new bits, with the errors kept. The random phase then drives writes and strobes independently each cycle, so both collisions recur many times. Every read, both pins and the start pulse are compared with a bench model that applies event bits after the mask and judges command acceptance on the master bit as it stood before the edge.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int DW = 16;

  // interrupt status bit positions
  localparam int B_MASTER = 15;
  localparam int B_RSTDN  = 4;
  localparam int B_ERSDN  = 5;
  localparam int B_PRGDN  = 6;
  localparam int B_LDDN   = 7;

  // lowest controller status error bit; errors occupy consecutive bits
  localparam int B_ERR_LSB = 10;

  // configuration bit positions and read mask width
  localparam int B_POL      = 6;
  localparam int B_RDY      = 7;
  localparam int CFG_HIDE_W = 5;

  localparam logic [DW-1:0] CFG_RST_VAL  = 16'h40C0;
  localparam logic [DW-1:0] INT_COLD_VAL = 16'h8080;
  localparam logic [DW-1:0] INT_WARM_VAL = 16'h8010;

  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_CMD  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rst_done;
    logic erase_done;
    logic prog_done;
    logic load_done;
    logic generic;
  } done_evt_t;
endpackage

// File: rtl/flash_irq_rstsync.sv
module flash_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
#(
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  done_evt_t          evt,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               clr_we,
  input  logic [DW-1:0]      clr_val,
  output logic [DW-1:0]      int_q,
  output logic [DW-1:0]      stat_q
);
  logic [DW-1:0]      evt_bits;
  logic [DW-1:0]      int_d;
  logic [NUM_ERR-1:0] err_q;
  logic [NUM_ERR-1:0] err_d;
  logic               upd_en;

  // bits contributed by completion and error strobes
  always_comb begin
    evt_bits = '0;
    if (evt.rst_done)   evt_bits[B_RSTDN] = 1'b1;
    if (evt.erase_done) evt_bits[B_ERSDN] = 1'b1;
    if (evt.prog_done)  evt_bits[B_PRGDN] = 1'b1;
    if (evt.load_done)  evt_bits[B_LDDN]  = 1'b1;
    if ((|evt) || (|err_evt)) evt_bits[B_MASTER] = 1'b1;
  end

  // next state: mask first, then events, then error rule
  always_comb begin
    int_d = clr_we ? (int_q & clr_val) : int_q;
    int_d = int_d | evt_bits;
    err_d = int_d[B_MASTER] ? (err_q | err_evt) : '0;
    if (soft_rst) begin
      int_d = INT_WARM_VAL;
      err_d = '0;
    end
    upd_en = soft_rst | clr_we | (|evt_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= INT_COLD_VAL;
      err_q <= '0;
    end else if (upd_en) begin
      int_q <= int_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    stat_q = '0;
    for (int i = 0; i < NUM_ERR; i++) stat_q[B_ERR_LSB+i] = err_q[i];
  end
endmodule

// File: rtl/flash_irq_cfgcmd.sv
module flash_irq_cfgcmd
  import flash_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cfg_we,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] cmd_q,
  output logic          go_q
);
  logic          cmd_ok;
  logic          cfg_en;
  logic          cmd_en;
  logic [DW-1:0] cfg_d;
  logic [DW-1:0] cmd_d;

  always_comb begin
    cmd_ok = cmd_we & ~busy & ~soft_rst;
    cfg_en = soft_rst | cfg_we;
    cmd_en = soft_rst | cmd_ok;
    cfg_d  = soft_rst ? CFG_RST_VAL : wdata;
    cmd_d  = soft_rst ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST_VAL;
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (cmd_en) cmd_q <= cmd_d;
      go_q <= cmd_ok;
    end
  end
endmodule

// File: rtl/flash_irq_pins.sv
module flash_irq_pins #(
  parameter logic INT_RST = 1'b1,
  parameter logic RDY_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic pol_cfg,
  input  logic rdy_cfg,
  output logic int_o,
  output logic rdy_o
);
  logic int_d;
  logic rdy_d;

  always_comb begin
    int_d = master ^ ~pol_cfg;
    rdy_d = rdy_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_o <= INT_RST;
      rdy_o <= RDY_RST;
    end else begin
      int_o <= int_d;
      rdy_o <= rdy_d;
    end
  end
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_ERR     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_i,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               evt_rst_done_i,
  input  logic               evt_erase_done_i,
  input  logic               evt_prog_done_i,
  input  logic               evt_load_done_i,
  input  logic               evt_generic_i,
  input  logic [NUM_ERR-1:0] evt_err_i,
  output logic               cmd_go_o,
  output logic [DW-1:0]      cmd_code_o,
  output logic               int_o,
  output logic               rdy_o
);
  localparam logic INT_PIN_RST = INT_COLD_VAL[B_MASTER] ^ ~CFG_RST_VAL[B_POL];
  localparam logic RDY_PIN_RST = CFG_RST_VAL[B_RDY];

  reg_sel_e      sel;
  done_evt_t     evt;
  logic          rst_sync_n;
  logic [DW-1:0] int_q;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] cmd_q;

  always_comb begin
    sel            = reg_sel_e'(reg_addr_i);
    evt.rst_done   = evt_rst_done_i;
    evt.erase_done = evt_erase_done_i;
    evt.prog_done  = evt_prog_done_i;
    evt.load_done  = evt_load_done_i;
    evt.generic    = evt_generic_i;
  end

  flash_irq_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flash_irq_status #(.NUM_ERR(NUM_ERR)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst_i),
    .evt      (evt),
    .err_evt  (evt_err_i),
    .clr_we   (reg_wr_i && (sel == SEL_INT)),
    .clr_val  (reg_wdata_i),
    .int_q    (int_q),
    .stat_q   (stat_q)
  );

  flash_irq_cfgcmd u_cfgcmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .soft_rst (soft_rst_i),
    .cfg_we   (reg_wr_i && (sel == SEL_CFG)),
    .cmd_we   (reg_wr_i && (sel == SEL_CMD)),
    .wdata    (reg_wdata_i),
    .busy     (int_q[B_MASTER]),
    .cfg_q    (cfg_q),
    .cmd_q    (cmd_q),
    .go_q     (cmd_go_o)
  );

  flash_irq_pins #(.INT_RST(INT_PIN_RST), .RDY_RST(RDY_PIN_RST)) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .master  (int_q[B_MASTER]),
    .pol_cfg (cfg_q[B_POL]),
    .rdy_cfg (cfg_q[B_RDY]),
    .int_o   (int_o),
    .rdy_o   (rdy_o)
  );

  always_comb begin
    unique case (sel)
      SEL_INT:  reg_rdata_o = int_q;
      SEL_STAT: reg_rdata_o = stat_q;
      SEL_CFG:  reg_rdata_o = {cfg_q[DW-1:CFG_HIDE_W], {CFG_HIDE_W{1'b0}}};
      SEL_CMD:  reg_rdata_o = cmd_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign cmd_code_o = cmd_q;
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        soft_rst_i,
  input logic        reg_wr_i,
  input logic [1:0]  reg_addr_i,
  input logic        evt_load_done_i,
  input logic [15:0] int_q,
  input logic [15:0] stat_q,
  input logic [15:0] cfg_q,
  input logic        cmd_go_o,
  input logic        int_o,
  input logic        rdy_o
);
  // R2: soft reset loads the warm values
  a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst_i |=> (int_q == 16'h8010) && (stat_q == 16'h0000));

  // R3: load completion leaves master and load bits set
  a_r3_load_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_load_done_i && !soft_rst_i) |=> (int_q[15] && int_q[7]));

  // R6: no error bit without the master bit
  a_r6_err_needs_master: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_q != 16'h0000) |-> int_q[15]);

  // R8: a start pulse only follows an accepted command write
  a_r8_cmd_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_go_o |-> $past(reg_wr_i && (reg_addr_i == 2'd3) && !int_q[15]));

  // R9: interrupt pin lags the polarity-corrected master bit
  a_r9_int_pin: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (int_o == ($past(int_q[15]) ^ ~$past(cfg_q[6]))));

  // R10: ready pin lags configuration bit 7
  a_r10_rdy_pin: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rdy_o == $past(cfg_q[7])));
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk u_flash_irq_ctrl_chk (
  .clk             (clk),
  .rst_sync_n      (rst_sync_n),
  .soft_rst_i      (soft_rst_i),
  .reg_wr_i        (reg_wr_i),
  .reg_addr_i      (reg_addr_i),
  .evt_load_done_i (evt_load_done_i),
  .int_q           (int_q),
  .stat_q          (stat_q),
  .cfg_q           (cfg_q),
  .cmd_go_o        (cmd_go_o),
  .int_o           (int_o),
  .rdy_o           (rdy_o)
);

// File: tb/flash_irq_ctrl_bench.sv
module flash_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst_i;
  logic        reg_wr_i;
  logic [1:0]  reg_addr_i;
  logic [15:0] reg_wdata_i;
  logic [15:0] reg_rdata_o;
  logic        evt_rst_done_i, evt_erase_done_i, evt_prog_done_i;
  logic        evt_load_done_i, evt_generic_i;
  logic [3:0]  evt_err_i;
  logic        cmd_go_o;
  logic [15:0] cmd_code_o;
  logic        int_o, rdy_o;

  int checks   = 0;
  int failures = 0;

  // model state
  logic [15:0] m_int, m_cfg, m_cmd;
  logic [3:0]  m_err;
  logic        m_go, m_ipin, m_rpin;

  always #5 clk = ~clk;

  flash_irq_ctrl u_flash_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .evt_rst_done_i(evt_rst_done_i), .evt_erase_done_i(evt_erase_done_i),
    .evt_prog_done_i(evt_prog_done_i), .evt_load_done_i(evt_load_done_i),
    .evt_generic_i(evt_generic_i), .evt_err_i(evt_err_i),
    .cmd_go_o(cmd_go_o), .cmd_code_o(cmd_code_o), .int_o(int_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_int;
      2'd1:    return {2'b00, m_err, 10'd0};
      2'd2:    return {m_cfg[15:5], 5'd0};
      default: return m_cmd;
    endcase
  endfunction

  // one clock: drive after negedge, model at posedge, check at next negedge
  task automatic step(input logic s, input logic wr, input logic [1:0] a,
                      input logic [15:0] w, input logic [4:0] ev, input logic [3:0] er);
    logic [15:0] evb, ni;
    logic        go, ip_n, rp_n;
    string       tag;
    soft_rst_i = s; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = w;
    {evt_rst_done_i, evt_erase_done_i, evt_prog_done_i, evt_load_done_i, evt_generic_i} = ev;
    evt_err_i = er;
    @(posedge clk);
    ip_n = m_int[15] ^ ~m_cfg[6];
    rp_n = m_cfg[7];
    if (s) begin
      m_int = 16'h8010; m_cfg = 16'h40C0; m_err = 4'd0; m_cmd = 16'd0; m_go = 1'b0;
    end else begin
      evb = 16'd0;
      if (ev[4]) evb |= 16'h8010;
      if (ev[3]) evb |= 16'h8020;
      if (ev[2]) evb |= 16'h8040;
      if (ev[1]) evb |= 16'h8080;
      if (ev[0]) evb |= 16'h8000;
      if (|er)   evb |= 16'h8000;
      go = wr && (a == 2'd3) && !m_int[15];
      ni = (wr && a == 2'd0) ? (m_int & w) : m_int;
      ni |= evb;
      m_err = ni[15] ? (m_err | er) : 4'd0;
      m_int = ni;
      if (wr && a == 2'd2) m_cfg = w;
      if (go) m_cmd = w;
      m_go = go;
    end
    m_ipin = ip_n; m_rpin = rp_n;
    @(negedge clk);
    case (a)
      2'd0: tag = "R3/R5";
      2'd1: tag = "R4";
      2'd2: tag = "R11";
      default: tag = "R8";
    endcase
    chk(tag, reg_rdata_o, exp_read(a));
    chk("R9 int_o", {15'd0, int_o}, {15'd0, m_ipin});
    chk("R10 rdy_o", {15'd0, rdy_o}, {15'd0, m_rpin});
    chk("R8 cmd_go_o", {15'd0, cmd_go_o}, {15'd0, m_go});
    if (m_go) chk("R8 cmd_code_o", cmd_code_o, m_cmd);
  endtask

  task automatic idle(input logic [1:0] a);
    step(1'b0, 1'b0, a, 16'h0000, 5'd0, 4'd0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; soft_rst_i = 0; reg_wr_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    evt_rst_done_i = 0; evt_erase_done_i = 0; evt_prog_done_i = 0;
    evt_load_done_i = 0; evt_generic_i = 0; evt_err_i = 0;
    m_int = 16'h8080; m_cfg = 16'h40C0; m_cmd = 0; m_err = 0; m_go = 0;
    m_ipin = 1'b1; m_rpin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle(2'd0);

    // R1 reset state
    idle(2'd0); chk("R1 int", reg_rdata_o, 16'h8080);
    idle(2'd2); chk("R1 cfg", reg_rdata_o, 16'h40C0);
    idle(2'd1); chk("R1 stat", reg_rdata_o, 16'h0000);
    chk("R1 pins", {14'd0, int_o, rdy_o}, 16'h0003);

    // R8 command refused while master set
    step(0, 1, 2'd3, 16'h0094, 5'd0, 4'd0);
    chk("R8 refused", {15'd0, cmd_go_o}, 16'd0);
    idle(2'd3); chk("R8 code kept", reg_rdata_o, 16'h0000);

    // R5 AND clear of master only
    step(0, 1, 2'd0, 16'h7FFF, 5'd0, 4'd0);
    idle(2'd0); chk("R5 and", reg_rdata_o, 16'h0080);

    // R8 accepted command
    step(0, 1, 2'd3, 16'h00E0, 5'd0, 4'd0);
    chk("R8 go", {15'd0, cmd_go_o}, 16'd1);
    chk("R8 code", cmd_code_o, 16'h00E0);
    idle(2'd3); chk("R8 pulse width", {15'd0, cmd_go_o}, 16'd0);

    // R4 errors with program completion
    step(0, 0, 2'd1, 16'h0000, 5'b00100, 4'b0101);
    chk("R4 stat", reg_rdata_o, 16'h1400);
    idle(2'd0); chk("R3 prog", reg_rdata_o, 16'h80C0);

    // R7 clear and erase completion in the same cycle
    step(0, 1, 2'd0, 16'h7FFF, 5'b01000, 4'd0);
    chk("R7 int", reg_rdata_o, 16'h80E0);
    idle(2'd1); chk("R7 err kept", reg_rdata_o, 16'h1400);

    // R6 full clear drops errors
    step(0, 1, 2'd0, 16'h0000, 5'd0, 4'd0);
    idle(2'd1); chk("R6 err cleared", reg_rdata_o, 16'h0000);

    // R9 polarity flip; R10 ready bit; R11 read mask
    step(0, 1, 2'd2, 16'h009F, 5'd0, 4'd0);
    idle(2'd2); chk("R11 mask", reg_rdata_o, 16'h0080);
    chk("R9 low-active pin", {15'd0, int_o}, 16'd1);
    step(0, 1, 2'd2, 16'h001F, 5'd0, 4'd0);
    idle(2'd2); chk("R10 rdy low", {15'd0, rdy_o}, 16'd0);
    step(0, 1, 2'd1, 16'hFFFF, 5'd0, 4'd0);
    chk("R11 stat ignores write", reg_rdata_o, 16'h0000);

    // R2 soft reset beats a same-cycle event
    step(1, 1, 2'd0, 16'hFFFF, 5'b00010, 4'b1000);
    chk("R2 int", reg_rdata_o, 16'h8010);
    idle(2'd2); chk("R2 cfg", reg_rdata_o, 16'h40C0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic s, wr;
      logic [1:0] a;
      logic [15:0] w;
      logic [4:0] ev;
      logic [3:0] er;
      s  = ($urandom_range(0, 199) == 0);
      wr = $urandom_range(0, 1);
      a  = 2'($urandom_range(0, 3));
      w  = 16'($urandom);
      if (a == 2'd0 && $urandom_range(0, 1)) w[15] = 1'b0;
      ev = '0;
      for (int k = 0; k < 5; k++) ev[k] = ($urandom_range(0, 15) == 0);
      er = '0;
      for (int k = 0; k < 4; k++) er[k] = ($urandom_range(0, 31) == 0);
      step(s, wr, a, w, ev, er);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule